// File: doc/BRIEF.md
# Packet container packer

The block gathers incoming packets, delivered one byte per cycle, into fixed-size containers of 32-bit words. Each container holds a header region followed by packet payload. The header carries a table of 16-bit packet byte lengths and, in its first word, the number of packets and the number of words in use. Payload for each packet starts on a fresh word. Unused byte lanes of a packet's last word are written as zero.

Two containers are filled in turn. A container is closed when the next packet would not fit in its remaining space, or as soon as it holds the maximum packet count. Closing writes the summary word and raises that container's full flag. The packer then moves to the other container. A downstream mover drains a full container and pulses its release line, which makes the container writable again. A packet that starts while the packer's current container is full is consumed and discarded, and a one-cycle drop pulse is raised.

All writes leave the block on a single registered, word-addressed port with byte enables. The port addresses an external two-container memory.

Top module: `pkt_container_packer`

## Requirements
- R1: When a packet is accepted as the i-th packet of a container (i counted from 0), its byte length is written into header word 1 + i/2: bits [31:16] when i is even, bits [15:0] when i is odd. This write uses byte enables 4'b1100 or 4'b0011, so the other half of the word is left untouched.
- R2: Byte j of a packet is stored in bits [8*(j mod 4)+7 : 8*(j mod 4)] of data word (start + j/4). A packet's start word is the word that follows the previous packet's last word. Byte lanes past the end of the packet in its last word are written as zero.
- R3: After reset or release, the first packet placed in a container begins at word 34. Words 0 to 33 are the header.
- R4: A packet of L bytes, where 1 <= L <= 3960, needs ceil(L/4) words. If that would take the next free word index past 1024, the container is closed first and the packet goes to the other container. A packet that ends exactly at word 1023 is accepted.
- R5: A container is closed in the cycles right after its 66th packet ends, without waiting for another packet.
- R6: Closing writes word 0 of the container as {words in use including the 34 header words [31:16], packet count [15:0]} with all byte enables set. The container's full flag rises in the same cycle as that write, and filling moves to the other container.
- R7: If the current container is full when a packet starts, the whole packet is accepted and discarded. No memory write takes place, and drop_pulse is high for exactly one cycle.
- R8: A one-cycle pulse on cont_release[c] clears cont_full[c]. Filling of that container resumes at word 34 with a packet count of 0.
- R9: After reset, both full flags are 0, drop_pulse and mem_we are 0, s_ready is 0, and container 0 is the current container.
- R10: mem_addr is {container index, 10-bit word index}, with container 0 at the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Byte beat valid |
| s_ready | output | 1 | Beat accepted on a cycle with s_valid high |
| s_first | input | 1 | Beat is the first byte of a packet |
| s_last | input | 1 | Beat is the last byte of a packet |
| s_data | input | 8 | Packet byte |
| s_len | input | 16 | Packet byte length, held valid for all beats of the packet |
| cont_release | input | 2 | Per-container release pulse from the downstream mover |
| cont_full | output | 2 | Per-container full flag |
| drop_pulse | output | 1 | One-cycle pulse when a packet is discarded |
| mem_we | output | 1 | Container memory write strobe |
| mem_addr | output | 11 | {container, word index} |
| mem_be | output | 4 | Byte enables of the write |
| mem_wdata | output | 32 | Write data |

## Verification
The hardest state to reach is the discard path, because it needs both containers full at the moment a packet begins. The stimulus gets there on purpose. It fills one container exactly to its last word with a 3960-byte packet. A short packet then forces that container to close and starts the second one. A second maximum-size packet no longer fits, so the second container closes and the packer points back at the first container, which is still full. The bench then confirms that the drop pulse fired and that the memory of both closed containers is unchanged. After that, it releases the containers and checks that the packer reuses them from word 34. Random packet sizes and random release timing then mix overflow closes, closes at the 66-packet limit and further discards.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_CLOSE = 2'd2,
    ST_DROP  = 2'd3
  } pcp_state_e;

  // byte enables for one 16-bit half of a header word
  function automatic logic [3:0] half_be(input logic odd_slot);
    return odd_slot ? 4'b0011 : 4'b1100;
  endfunction

endpackage

// File: rtl/pcp_fit_check.sv
module pcp_fit_check #(
  parameter int CONT_WORDS = 1024,
  parameter int LEN_W      = 16,
  parameter int PTR_W      = 11
) (
  input  logic [PTR_W-1:0] wptr,
  input  logic [LEN_W-1:0] len,
  output logic             fits
);
  localparam int SUM_W = LEN_W + 2;

  logic [SUM_W-1:0] need_words;
  logic [SUM_W-1:0] end_ptr;

  always_comb begin
    need_words = (SUM_W'(len) + SUM_W'(3)) >> 2;
    end_ptr    = SUM_W'(wptr) + need_words;
    fits       = (end_ptr <= SUM_W'(CONT_WORDS));
  end

endmodule

// File: rtl/pcp_word_asm.sv
module pcp_word_asm #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              last_i,
  input  logic [7:0]        byte_i,
  output logic [WORD_W-1:0] word_o,
  output logic              emit_o
);
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] acc;

  always_comb begin
    word_o = (lane == '0) ? '0 : acc;
    word_o[8*lane +: 8] = byte_i;
    emit_o = take && ((lane == LANE_W'(LANES - 1)) || last_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane <= '0;
      acc  <= '0;
    end else if (take) begin
      lane <= last_i ? '0 : lane + LANE_W'(1);
      acc  <= word_o;
    end
  end

endmodule

// File: rtl/pcp_flag_pair.sv
module pcp_flag_pair #(
  parameter int NCONT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCONT-1:0] set_i,
  input  logic [NCONT-1:0] rel_i,
  output logic [NCONT-1:0] full_o
);

  for (genvar g = 0; g < NCONT; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           full_o[g] <= 1'b0;
      else if (set_i[g]) full_o[g] <= 1'b1;
      else if (rel_i[g]) full_o[g] <= 1'b0;
    end

    p_release_clears_r8: assert property (@(posedge clk) disable iff (rst)
      (full_o[g] && rel_i[g] && !set_i[g]) |=> !full_o[g]);
  end

endmodule

// File: rtl/pkt_container_packer.sv
module pkt_container_packer
  import pcp_pkg::*;
#(
  parameter int CONT_WORDS = 1024,
  parameter int MAX_PKTS   = 66,
  parameter int LEN_W      = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               s_valid,
  output logic                               s_ready,
  input  logic                               s_first,
  input  logic                               s_last,
  input  logic [7:0]                         s_data,
  input  logic [LEN_W-1:0]                   s_len,
  input  logic [1:0]                         cont_release,
  output logic [1:0]                         cont_full,
  output logic                               drop_pulse,
  output logic                               mem_we,
  output logic [$clog2(CONT_WORDS):0]        mem_addr,
  output logic [3:0]                         mem_be,
  output logic [31:0]                        mem_wdata
);
  localparam int HDR_WORDS = 1 + MAX_PKTS / 2;
  localparam int IDX_W     = $clog2(CONT_WORDS);
  localparam int PTR_W     = $clog2(CONT_WORDS + 1);
  localparam int CNT_W     = $clog2(MAX_PKTS + 1);

  pcp_state_e        state;
  logic              cur;
  logic [PTR_W-1:0]  wptr;
  logic [CNT_W-1:0]  cnt;
  logic              fits;
  logic              beat;
  logic              take;
  logic [31:0]       asm_word;
  logic              asm_emit;
  logic [1:0]        close_set;

  assign s_ready   = (state == ST_DATA) || (state == ST_DROP);
  assign beat      = s_valid && s_ready;
  assign take      = beat && (state == ST_DATA);
  assign close_set = (state == ST_CLOSE) ? (cur ? 2'b10 : 2'b01) : 2'b00;

  pcp_fit_check #(
    .CONT_WORDS(CONT_WORDS), .LEN_W(LEN_W), .PTR_W(PTR_W)
  ) i_fit (
    .wptr(wptr), .len(s_len), .fits(fits)
  );

  pcp_word_asm #(.WORD_W(32)) i_asm (
    .clk(clk), .rst(rst), .take(take), .last_i(s_last),
    .byte_i(s_data), .word_o(asm_word), .emit_o(asm_emit)
  );

  pcp_flag_pair #(.NCONT(2)) i_flags (
    .clk(clk), .rst(rst), .set_i(close_set), .rel_i(cont_release),
    .full_o(cont_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur        <= 1'b0;
      wptr       <= PTR_W'(HDR_WORDS);
      cnt        <= '0;
      drop_pulse <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
    end else begin
      mem_we     <= 1'b0;
      drop_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (s_valid && s_first) begin
            if (cont_full[cur]) begin
              drop_pulse <= 1'b1;
              state      <= ST_DROP;
            end else if (!fits) begin
              state <= ST_CLOSE;
            end else begin
              // length table entry is known at the first beat
              mem_we    <= 1'b1;
              mem_addr  <= {cur, IDX_W'(cnt >> 1) + IDX_W'(1)};
              mem_be    <= half_be(cnt[0]);
              mem_wdata <= {2{16'(s_len)}};
              state     <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (take) begin
            if (asm_emit) begin
              mem_we    <= 1'b1;
              mem_addr  <= {cur, wptr[IDX_W-1:0]};
              mem_be    <= 4'hF;
              mem_wdata <= asm_word;
              wptr      <= wptr + PTR_W'(1);
            end
            if (s_last) begin
              cnt   <= cnt + CNT_W'(1);
              state <= (cnt + CNT_W'(1) == CNT_W'(MAX_PKTS)) ? ST_CLOSE : ST_IDLE;
            end
          end
        end
        ST_CLOSE: begin
          mem_we    <= 1'b1;
          mem_addr  <= {cur, IDX_W'(0)};
          mem_be    <= 4'hF;
          mem_wdata <= {16'(wptr), 16'(cnt)};
          cur       <= ~cur;
          wptr      <= PTR_W'(HDR_WORDS);
          cnt       <= '0;
          state     <= ST_IDLE;
        end
        ST_DROP: begin
          if (beat && s_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // assertions
  p_drop_single_r7: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |=> !drop_pulse);

  p_drop_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DROP) |-> !mem_we);

  p_close_word0_c0_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cont_full[0]) |-> (mem_we && mem_addr == {1'b0, IDX_W'(0)} && mem_be == 4'hF));

  p_close_word0_c1_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cont_full[1]) |-> (mem_we && mem_addr == {1'b1, IDX_W'(0)} && mem_be == 4'hF));

  p_count_limit_r5: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= MAX_PKTS);

  p_space_limit_r4: assert property (@(posedge clk) disable iff (rst)
    int'(wptr) <= CONT_WORDS);

  p_header_half_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be != 4'hF) |->
      (int'(mem_addr[IDX_W-1:0]) >= 1 && int'(mem_addr[IDX_W-1:0]) < HDR_WORDS));

  p_data_region_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be == 4'hF && mem_addr[IDX_W-1:0] != '0) |->
      int'(mem_addr[IDX_W-1:0]) >= HDR_WORDS);

endmodule

// File: tb/test_pkt_container_packer.sv
`timescale 1ns/1ps
module test_pkt_container_packer;

  logic        clk = 1'b0;
  logic        rst;
  logic        s_valid, s_ready, s_first, s_last;
  logic [7:0]  s_data;
  logic [15:0] s_len;
  logic [1:0]  cont_release, cont_full;
  logic        drop_pulse, mem_we;
  logic [10:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;

  always #2.5 clk = ~clk;

  pkt_container_packer i_pkt_container_packer (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_first(s_first), .s_last(s_last), .s_data(s_data), .s_len(s_len),
    .cont_release(cont_release), .cont_full(cont_full),
    .drop_pulse(drop_pulse), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata)
  );

  int checks = 0;
  int failures = 0;

  logic [31:0] dut_mem [0:1][0:1023];
  logic [31:0] exp_mem [0:1][0:1023];
  logic [7:0]  pbytes [0:4095];
  int  m_cur, m_wptr, m_cnt;
  bit  m_full [0:1];
  bit  new_closed [0:1];
  int  exp_drops = 0;
  int  seen_drops = 0;

  // external container memory with byte enables
  always @(negedge clk) begin
    if (!rst && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) dut_mem[mem_addr[10]][mem_addr[9:0]][8*b +: 8] = mem_wdata[8*b +: 8];
    if (!rst && drop_pulse) seen_drops++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int need_words(input int len);
    return (len + 3) / 4;
  endfunction

  task automatic clear_cont(input int c);
    for (int w = 0; w < 1024; w++) begin
      dut_mem[c][w] = '0;
      exp_mem[c][w] = '0;
    end
  endtask

  task automatic model_close();
    exp_mem[m_cur][0] = {m_wptr[15:0], m_cnt[15:0]};
    m_full[m_cur] = 1'b1;
    new_closed[m_cur] = 1'b1;
    m_cur = 1 - m_cur;
    m_wptr = 34;
    m_cnt = 0;
  endtask

  task automatic check_cont(input int c, input string req);
    int bad = -1;
    for (int w = 1023; w >= 0; w--)
      if (dut_mem[c][w] !== exp_mem[c][w]) bad = w;
    if (bad < 0) chk(1'b1, req, "container image", '0, '0);
    else chk(1'b0, req, $sformatf("container %0d word %0d", c, bad),
             dut_mem[c][bad], exp_mem[c][bad]);
  endtask

  task automatic check_state(input string req);
    chk(cont_full === {m_full[1], m_full[0]}, req, "full flags",
        {30'd0, cont_full}, {30'd0, m_full[1], m_full[0]});
    chk(seen_drops == exp_drops, "R7", "drop count", seen_drops, exp_drops);
    for (int c = 0; c < 2; c++)
      if (new_closed[c]) begin
        check_cont(c, "R1 R2 R3 R6");
        new_closed[c] = 1'b0;
      end
  endtask

  task automatic send(input int len);
    for (int j = 0; j < len; j++) pbytes[j] = 8'($urandom);
    // expected placement
    if (!m_full[m_cur] && m_wptr + need_words(len) > 1024) model_close();
    if (m_full[m_cur]) begin
      exp_drops++;
    end else begin
      if (m_cnt % 2 == 0) exp_mem[m_cur][1 + m_cnt/2][31:16] = 16'(len);
      else                exp_mem[m_cur][1 + m_cnt/2][15:0]  = 16'(len);
      for (int j = 0; j < len; j++)
        exp_mem[m_cur][m_wptr + j/4][8*(j%4) +: 8] = pbytes[j];
      m_wptr += need_words(len);
      m_cnt++;
      if (m_cnt == 66) model_close();
    end
    for (int j = 0; j < len; j++) begin
      s_valid = 1'b1;
      s_first = (j == 0);
      s_last  = (j == len - 1);
      s_data  = pbytes[j];
      s_len   = 16'(len);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_first = 1'b0;
    s_last  = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic release_cont(input int c);
    cont_release[c] = 1'b1;
    @(negedge clk);
    cont_release[c] = 1'b0;
    @(negedge clk);
    chk(cont_full[c] === 1'b0, "R8", "flag after release", {31'd0, cont_full[c]}, 32'd0);
    m_full[c] = 1'b0;
    clear_cont(c);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0; s_data = '0; s_len = '0;
    cont_release = '0;
    clear_cont(0); clear_cont(1);
    m_cur = 0; m_wptr = 34; m_cnt = 0;
    m_full[0] = 0; m_full[1] = 0; new_closed[0] = 0; new_closed[1] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(cont_full === 2'b00, "R9", "full after reset", {30'd0, cont_full}, 32'd0);
    chk(drop_pulse === 1'b0 && mem_we === 1'b0, "R9", "idle strobes",
        {30'd0, drop_pulse, mem_we}, 32'd0);
    chk(s_ready === 1'b0, "R9", "ready while idle", {31'd0, s_ready}, 32'd0);

    // R4 exact fit, R10 container select, R7 both-full discard
    send(3960);
    check_state("R4");
    chk(dut_mem[0][1023] === exp_mem[0][1023], "R4", "last word exact fit",
        dut_mem[0][1023], exp_mem[0][1023]);
    send(4);
    check_state("R4");
    chk(dut_mem[1][34] === exp_mem[1][34], "R10", "second container data",
        dut_mem[1][34], exp_mem[1][34]);
    send(3960);
    check_state("R7");
    send(100);
    check_state("R7");
    check_cont(0, "R7");
    check_cont(1, "R7");
    release_cont(0);
    send(9);
    check_state("R8");
    chk(dut_mem[0][34] === exp_mem[0][34], "R8", "reuse at word 34",
        dut_mem[0][34], exp_mem[0][34]);
    release_cont(1);

    // R5 close at 66 packets
    for (int k = 0; k < 70; k++) begin
      send(1 + int'($urandom % 12));
      check_state("R5");
    end
    for (int c = 0; c < 2; c++) if (m_full[c]) release_cont(c);

    // random mix
    for (int k = 0; k < 60; k++) begin
      int sel = int'($urandom % 10);
      int len;
      if (sel < 7)      len = 60 + int'($urandom % 1479);
      else if (sel < 9) len = 1 + int'($urandom % 16);
      else              len = 1539 + int'($urandom % 2422);
      send(len);
      check_state("R4");
      for (int c = 0; c < 2; c++)
        if (m_full[c] && ($urandom % 2 == 0)) release_cont(c);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule